// File: doc/BRIEF.md
# Audio Playback Sequencer

This block follows the life cycle of an isochronous audio sink and drives its status flags. An audio stream has a fixed life: the receiver waits idle, captures one millisecond packet of samples, and starts output on the next start-of-frame strobe. It then plays until the host drops the stream. After that it drains whatever is still buffered and returns to idle. Whenever it is not playing, a select line tells the sample path to send bipolar zero, and the zero-data flag is held high.

A saturating run counter watches the sample stream. The zero-data flag rises once the counter has seen `ZERO_RUN` consecutive zero samples. A bus suspend overrides every state. It drops the active-low suspend flag, sends the sequencer back to idle and releases the playback flag. Packet storage, clock recovery and the analog path are handled by neighbouring blocks. The only input the sequencer takes from them is a buffer-empty indication.

Top module: `playback_seq`

## Requirements
- R1: After reset `play_n`=1, `susp_n`=1, `zero_flag`=1 and `force_bpz`=1.
- R2: A `pkt_rx` strobe in idle does not start output: `play_n` stays 1 and `force_bpz` stays 1. A `sof` strobe in idle, or in the same cycle as the first `pkt_rx`, has no effect.
- R3: A `sof` strobe after a packet has been buffered drives `play_n` to 0 and `force_bpz` to 0 on the following clock edge.
- R4: While playing, `stream_on`=0 starts draining, and `play_n` stays 0. `play_n` returns to 1 and `force_bpz` to 1 on the edge where `buf_empty` is sampled 1 during draining.
- R5: While playing with `stream_on`=1, `buf_empty`=1 has no effect and `play_n` stays 0.
- R6: `susp_n` is the inverse of `bus_suspend`, registered once, so it follows one edge later.
- R7: `bus_suspend`=1 in any state drives `play_n` to 1 and `force_bpz` to 1 on the next edge. Output restarts only after a new `pkt_rx` and then a `sof`.
- R8: While playing, `zero_flag` goes to 1 on the edge that accepts the `ZERO_RUN`th consecutive zero sample (`smp_valid`=1, `smp_data`=0). After `ZERO_RUN`-1 zero samples it is still 0.
- R9: An accepted non-zero sample clears the run, so `zero_flag` goes to 0 on that edge while playing. The run saturates, so further zero samples keep `zero_flag` at 1. Cycles with `smp_valid`=0 neither add to nor clear the run.
- R10: Whenever `play_n`=1, `zero_flag` and `force_bpz` are both 1, whatever the sample data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_rx | input | 1 | Strobe: one audio packet has been stored |
| sof | input | 1 | Strobe: start-of-frame seen |
| bus_suspend | input | 1 | Bus is in suspend state |
| stream_on | input | 1 | Host stream is active |
| buf_empty | input | 1 | Sample buffer has no data left |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample value |
| play_n | output | 1 | Playback flag, low while playing or draining |
| susp_n | output | 1 | Suspend flag, low while suspended |
| zero_flag | output | 1 | Zero-data flag |
| force_bpz | output | 1 | Select: force output samples to bipolar zero |

## Verification
The bench targets these corner cases:
- A `sof` that arrives before any packet, or together with the first packet. A design that got this wrong would start playing an empty buffer.
- A `buf_empty` pulse during normal play. A wrong design would stop early.
- The zero run at exactly `ZERO_RUN`-1 and `ZERO_RUN` samples. An off-by-one counter would raise the flag one sample early or one sample late.
- A non-zero sample after saturation. A counter that only stopped counting, instead of clearing, would leave the flag stuck high.
- Gaps with no sample strobe in the middle of a zero run. Counting these gaps would raise the flag early.
- A suspend during playback, followed by a lone `sof`. This shows whether the buffered state is wrongly kept across a suspend.

// File: rtl/playback_seq.sv
module playback_seq #(
  parameter int SAMPLE_W = 16,
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_rx,
  input  logic                sof,
  input  logic                bus_suspend,
  input  logic                stream_on,
  input  logic                buf_empty,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                play_n,
  output logic                susp_n,
  output logic                zero_flag,
  output logic                force_bpz
);
  localparam int CW = $clog2(ZERO_RUN + 1);

  typedef enum logic [1:0] {IDLE, BUFFERED, PLAYING, DRAINING} state_t;

  state_t         state, state_nx;
  logic [CW-1:0]  run;
  logic           susp_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      IDLE:     if (pkt_rx)     state_nx = BUFFERED;
      BUFFERED: if (sof)        state_nx = PLAYING;
      PLAYING:  if (!stream_on) state_nx = DRAINING;
      DRAINING: if (buf_empty)  state_nx = IDLE;
      default:                  state_nx = IDLE;
    endcase
    if (bus_suspend) state_nx = IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      susp_q <= 1'b0;
    end else begin
      state  <= state_nx;
      susp_q <= bus_suspend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else if (smp_valid) begin
      if (smp_data != '0)
        run <= '0;
      else if (run != CW'(ZERO_RUN))
        run <= run + 1'b1;
    end
  end

  wire active = (state == PLAYING) || (state == DRAINING);

  assign play_n    = ~active;
  assign force_bpz = ~active;
  assign susp_n    = ~susp_q;
  assign zero_flag = ~active || (run == CW'(ZERO_RUN));
endmodule

// File: rtl/playback_seq_chk.sv
module playback_seq_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sof,
  input logic                bus_suspend,
  input logic                buf_empty,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                play_n,
  input logic                susp_n,
  input logic                zero_flag,
  input logic                force_bpz
);
  // R6
  susp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_suspend |=> !susp_n);

  // R7
  susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_suspend |=> (play_n && force_bpz));

  // R3
  start_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(play_n) |-> $past(sof));

  // R4
  end_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_n) |-> $past(buf_empty || bus_suspend));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_n |-> (zero_flag && force_bpz));

  // R9
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_data != '0 && !play_n && !bus_suspend && !buf_empty) |=> !zero_flag);
endmodule

bind playback_seq playback_seq_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sof(sof), .bus_suspend(bus_suspend),
  .buf_empty(buf_empty), .smp_valid(smp_valid), .smp_data(smp_data),
  .play_n(play_n), .susp_n(susp_n), .zero_flag(zero_flag), .force_bpz(force_bpz));

// File: tb/playback_seq_tb_top.sv
module playback_seq_tb_top;
  localparam int SW  = 16;
  localparam int RUN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_rx = 0, sof = 0, bus_suspend = 0, stream_on = 0, buf_empty = 0, smp_valid = 0;
  logic [SW-1:0] smp_data = '0;
  logic play_n, susp_n, zero_flag, force_bpz;

  int checks = 0, errors = 0, cycles = 0;
  int m_st = 0;   // 0 idle, 1 buffered, 2 playing, 3 draining
  int m_run = 0;
  bit m_susp = 0;

  always #10 clk = ~clk;

  playback_seq #(.SAMPLE_W(SW), .ZERO_RUN(RUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_rx(pkt_rx), .sof(sof), .bus_suspend(bus_suspend),
    .stream_on(stream_on), .buf_empty(buf_empty), .smp_valid(smp_valid), .smp_data(smp_data),
    .play_n(play_n), .susp_n(susp_n), .zero_flag(zero_flag), .force_bpz(force_bpz));

  function automatic int next_st(int s);
    int n = s;
    if (s == 0 && pkt_rx) n = 1;
    else if (s == 1 && sof) n = 2;
    else if (s == 2 && !stream_on) n = 3;
    else if (s == 3 && buf_empty) n = 0;
    if (bus_suspend) n = 0;
    return n;
  endfunction

  function automatic int next_run(int r);
    if (!smp_valid) return r;
    if (smp_data != 0) return 0;
    return (r < RUN) ? r + 1 : r;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit act;
    m_st = next_st(m_st);
    m_run = next_run(m_run);
    m_susp = bus_suspend;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    act = (m_st >= 2);
    chk("R3", "play_n", play_n, !act);
    chk("R10", "force_bpz", force_bpz, !act);
    chk("R8", "zero_flag", zero_flag, !act || m_run == RUN);
    chk("R6", "susp_n", susp_n, !m_susp);
  endtask

  task automatic clr();
    pkt_rx = 0; sof = 0; bus_suspend = 0; buf_empty = 0; smp_valid = 0; smp_data = '0;
  endtask

  task automatic start_play();
    clr(); stream_on = 1; pkt_rx = 1; step();
    clr(); sof = 1; step(); clr();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1", "play_n", play_n, 1); chk("R1", "susp_n", susp_n, 1);
    chk("R1", "zero_flag", zero_flag, 1); chk("R1", "force_bpz", force_bpz, 1);
    rst_n = 1;
    @(negedge clk);

    // R2: sof in idle, then sof with first packet
    stream_on = 1; sof = 1; step(); chk("R2", "sof in idle", play_n, 1);
    pkt_rx = 1; step(); chk("R2", "sof with packet", play_n, 1);
    chk("R2", "bpz while buffered", force_bpz, 1);
    clr(); sof = 1; step(); chk("R3", "start on sof", play_n, 0);
    chk("R3", "bpz released", force_bpz, 0);

    // R5
    clr(); buf_empty = 1; step(); step(); chk("R5", "empty while streaming", play_n, 0);

    // R8 / R9 zero run with gaps
    clr();
    for (int i = 0; i < RUN - 1; i++) begin
      smp_valid = 1; smp_data = '0; step();
      if (i == 500) begin smp_valid = 0; smp_data = 16'h1234; step(); step(); end
    end
    chk("R8", "run minus one", zero_flag, 0);
    smp_valid = 1; smp_data = '0; step(); chk("R8", "run reached", zero_flag, 1);
    repeat (5) step(); chk("R9", "saturated", zero_flag, 1);
    smp_data = 16'h0001; step(); chk("R9", "nonzero clears", zero_flag, 0);
    smp_data = '0; step(); chk("R9", "restart run", zero_flag, 0);

    // R4 drain
    clr(); stream_on = 0; step(); chk("R4", "draining", play_n, 0);
    step(); chk("R4", "still draining", play_n, 0);
    buf_empty = 1; step(); chk("R4", "drain done", play_n, 1);
    chk("R4", "bpz after drain", force_bpz, 1);
    chk("R10", "zero in idle", zero_flag, 1);

    // R6 / R7 suspend
    start_play(); chk("R3", "replay", play_n, 0);
    bus_suspend = 1; step(); chk("R6", "susp low", susp_n, 0);
    chk("R7", "suspend stops", play_n, 1); chk("R7", "suspend bpz", force_bpz, 1);
    clr(); step(); chk("R6", "susp high", susp_n, 1);
    sof = 1; step(); chk("R7", "sof after suspend", play_n, 1);

    // random phase
    clr(); stream_on = 1;
    for (int i = 0; i < 20000; i++) begin
      pkt_rx      = ($urandom % 8) == 0;
      sof         = ($urandom % 16) == 0;
      bus_suspend = ($urandom % 64) == 0;
      if (($urandom % 32) == 0) stream_on = ~stream_on;
      buf_empty   = ($urandom % 8) == 0;
      smp_valid   = ($urandom % 2) == 0;
      smp_data    = (($urandom % 256) == 0) ? SW'($urandom) : '0;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule